// File: doc/BRIEF.md
# Secure Register Access Address Filter

This block sits between a privileged request port and a 32-bit register bus. Each request carries a function code, an address and write data. The block forwards a read or a write to the bus only when two conditions hold: the function code names a supported operation, and the address matches an entry on a fixed allow list. Any other request gets an error response, and the bus never sees it.

The allow list mixes single registers with inclusive address windows. It covers device identity words, the reset-strap words, two fuse windows, the fuse control register, and four kinds of per-cluster clock register (divider, force, ratio, ratio status). Each clock register is listed twice, once for each of two clusters. A build parameter chooses between two clock-register layouts. The layouts differ in the addresses, in the stride to the second cluster, and in whether a separate ratio register exists.

All addresses are offsets from the parameter `REG_BASE`. A request is accepted only while the block is idle. The address decision is taken from registered request fields one cycle after acceptance. After that decision the block either runs one bus access or answers at once with an error.

Top module: `sec_reg_gate`

## Requirements
- R1: Function code 20 (read) with an allowed address drives exactly one bus read (`busSel`=1, `busWrite`=0) at that address. The response then has `rspErr`=0 and `rspRdata` equal to the `busRdata` sampled with `busDone`.
- R2: Function code 21 (write) with an allowed address drives one bus write (`busWrite`=1) carrying the request address and write data. The response has `rspErr`=0.
- R3: Any function code other than 20 or 21 gets `rspErr`=1 and `rspRdata`=0, and `busSel` stays low, whatever the address.
- R4: An address that is not on the allow list gets `rspErr`=1 and `rspRdata`=0, and `busSel` stays low, for both reads and writes.
- R5: Windows include both endpoints. The allowed offsets are 0x6F8200 through 0x6F8204, 0x6F8F00 through 0x6F8F1C, and 0x6F9000 through 0x6F93F8. One byte outside either endpoint is rejected.
- R6: The single registers at offsets 0x6F8008, 0x6F8240 and 0x6F8244 are allowed, and their immediate neighbours outside any window are rejected.
- R7: In layout A (`LAYOUT_B`=0), offsets 0x6F8278, 0x6F8280, 0x6F8284 and 0x6F8C94 are allowed. Each of these plus 0x14 is also allowed.
- R8: In layout B (`LAYOUT_B`=1), offsets 0x6F8278, 0x6F827C and 0x6F8C98 are allowed. Each of these plus 0x8 is also allowed. Layout-A-only addresses such as 0x6F8298 and 0x6F8C94 are rejected.
- R9: `reqReady` is high only when idle and falls in the cycle after an acceptance. An error response appears in the second cycle after the accepting edge. `rspValid` is a one-cycle pulse.
- R10: Once raised, `busSel` stays high until `busDone`, with `busAddr`, `busWrite` and `busWdata` stable. `busSel` and `rspValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle if valid |
| reqFunc | input | FUNC_W | Function code (20 read, 21 write) |
| reqAddr | input | ADDR_W | Absolute register address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Request rejected (invalid argument) |
| rspRdata | output | DATA_W | Read data, zero for writes and errors |
| busSel | output | 1 | Bus access in progress |
| busWrite | output | 1 | Bus access is a write |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data, valid with busDone |
| busDone | input | 1 | Bus access complete |

## Verification
The bench builds both layouts and drives the same request stream into them. The stream has directed probes at every listed single address, at every window endpoint and at one byte beyond each endpoint, which separates inclusive matching from exclusive or off-by-one matching. Function codes next to 20 and 21 show that the operation check is exact. Random addresses clustered around the listed entries, together with fully random addresses and codes, check the two layouts against each other. That comparison shows whether the cluster stride and the missing ratio entry follow the layout parameter. Bus and response fields are compared per request, and the error latency is counted in cycles.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_BUS   = 2'd2,
    ST_RESP  = 2'd3
  } gateState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;    // take request fields
    logic loadRdata;  // take bus read data
  } gateStrobe_t;

  localparam int FUNC_READ  = 20;
  localparam int FUNC_WRITE = 21;

endpackage

// File: rtl/sec_gate_path.sv
module sec_gate_path
  import sec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FUNC_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hF000_0000,
  parameter bit LAYOUT_B = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strb,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              allowOk,
  output logic              isWrite,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [DATA_W-1:0] heldWdata,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int NUM_SINGLE = 3;
  localparam int NUM_WIN    = 3;
  localparam int NUM_CLK    = LAYOUT_B ? 3 : 4;
  localparam logic [ADDR_W-1:0] CLK_STRIDE = LAYOUT_B ? ADDR_W'(32'h8) : ADDR_W'(32'h14);

  function automatic logic [ADDR_W-1:0] singleOff(int idx);
    case (idx)
      0:       return ADDR_W'(32'h6F8008);
      1:       return ADDR_W'(32'h6F8240);
      default: return ADDR_W'(32'h6F8244);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] winLo(int idx);
    case (idx)
      0:       return ADDR_W'(32'h6F8200);
      1:       return ADDR_W'(32'h6F8F00);
      default: return ADDR_W'(32'h6F9000);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] winHi(int idx);
    case (idx)
      0:       return ADDR_W'(32'h6F8204);
      1:       return ADDR_W'(32'h6F8F1C);
      default: return ADDR_W'(32'h6F93F8);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] clkOff(int idx);
    if (LAYOUT_B) begin
      case (idx)
        0:       return ADDR_W'(32'h6F8278);
        1:       return ADDR_W'(32'h6F827C);
        default: return ADDR_W'(32'h6F8C98);
      endcase
    end else begin
      case (idx)
        0:       return ADDR_W'(32'h6F8278);
        1:       return ADDR_W'(32'h6F8280);
        2:       return ADDR_W'(32'h6F8284);
        default: return ADDR_W'(32'h6F8C94);
      endcase
    end
  endfunction

  logic [FUNC_W-1:0] heldFunc;
  logic [NUM_SINGLE-1:0] singleHit;
  logic [NUM_WIN-1:0]    winHit;
  logic [2*NUM_CLK-1:0]  clkHit;
  logic funcOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldFunc  <= '0;
      heldAddr  <= '0;
      heldWdata <= '0;
      rspRdata  <= '0;
    end else begin
      if (strb.capture) begin
        heldFunc  <= reqFunc;
        heldAddr  <= reqAddr;
        heldWdata <= reqWdata;
        rspRdata  <= '0;
      end
      if (strb.loadRdata && !isWrite) rspRdata <= busRdata;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SINGLE; gi++) begin : gSingle
      assign singleHit[gi] = (heldAddr == REG_BASE + singleOff(gi));
    end
    for (gi = 0; gi < NUM_WIN; gi++) begin : gWin
      assign winHit[gi] = (heldAddr >= REG_BASE + winLo(gi)) &&
                          (heldAddr <= REG_BASE + winHi(gi));
    end
    for (gi = 0; gi < NUM_CLK; gi++) begin : gClk
      assign clkHit[2*gi]   = (heldAddr == REG_BASE + clkOff(gi));
      assign clkHit[2*gi+1] = (heldAddr == REG_BASE + clkOff(gi) + CLK_STRIDE);
    end
  endgenerate

  assign isWrite = (heldFunc == FUNC_W'(FUNC_WRITE));
  assign funcOk  = (heldFunc == FUNC_W'(FUNC_READ)) || isWrite;
  assign allowOk = funcOk && ((|singleHit) || (|winHit) || (|clkHit));

endmodule

// File: rtl/sec_gate_ctrl.sv
module sec_gate_ctrl
  import sec_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        allowOk,
  input  logic        busDone,
  output gateStrobe_t strb,
  output logic        busSel,
  output logic        rspValid,
  output logic        rspErr
);

  gateState_t curState, nxtState;

  always_comb begin
    nxtState = curState;
    case (curState)
      ST_IDLE:  if (reqValid) nxtState = ST_CHECK;
      ST_CHECK: nxtState = allowOk ? ST_BUS : ST_RESP;
      ST_BUS:   if (busDone) nxtState = ST_RESP;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      rspErr   <= 1'b0;
    end else begin
      curState <= nxtState;
      if (curState == ST_CHECK) rspErr <= !allowOk;
      else if (curState == ST_IDLE) rspErr <= 1'b0;
    end
  end

  assign reqReady       = (curState == ST_IDLE);
  assign strb.capture   = reqValid && reqReady;
  assign strb.loadRdata = (curState == ST_BUS) && busDone;
  assign busSel         = (curState == ST_BUS);
  assign rspValid       = (curState == ST_RESP);

  // rejected decision: error response next cycle, bus untouched
  assert_reject_no_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_CHECK && !allowOk) |=> (rspValid && rspErr && !busSel));

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busDone) |=> busSel);

  assert_bus_rsp_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busSel, rspValid}));

endmodule

// File: rtl/sec_reg_gate.sv
module sec_reg_gate
  import sec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FUNC_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hF000_0000,
  parameter bit LAYOUT_B = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              busSel,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busDone
);

  gateStrobe_t strb;
  logic allowOk;
  logic isWrite;

  sec_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .allowOk  (allowOk),
    .busDone  (busDone),
    .strb     (strb),
    .busSel   (busSel),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  sec_gate_path #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FUNC_W   (FUNC_W),
    .REG_BASE (REG_BASE),
    .LAYOUT_B (LAYOUT_B)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqFunc   (reqFunc),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busRdata  (busRdata),
    .allowOk   (allowOk),
    .isWrite   (isWrite),
    .heldAddr  (busAddr),
    .heldWdata (busWdata),
    .rspRdata  (rspRdata)
  );

  assign busWrite = busSel && isWrite;

  assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busDone) |=> ($stable(busAddr) && $stable(busWdata) && $stable(busWrite)));

  assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == '0));

endmodule

// File: tb/test_sec_reg_gate.sv
module test_sec_reg_gate;

  localparam logic [31:0] BASE = 32'hF000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        reqValid = 1'b0;
  logic [7:0]  reqFunc = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;

  logic        readyA, rspValidA, rspErrA, busSelA, busWriteA;
  logic [31:0] rspRdataA, busAddrA, busWdataA, busRdataA;
  logic        busDoneA;
  logic        readyB, rspValidB, rspErrB, busSelB, busWriteB;
  logic [31:0] rspRdataB, busAddrB, busWdataB, busRdataB;
  logic        busDoneB;

  sec_reg_gate #(.REG_BASE(BASE), .LAYOUT_B(1'b0)) i_sec_reg_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(readyA),
    .reqFunc(reqFunc), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValidA), .rspErr(rspErrA), .rspRdata(rspRdataA),
    .busSel(busSelA), .busWrite(busWriteA), .busAddr(busAddrA),
    .busWdata(busWdataA), .busRdata(busRdataA), .busDone(busDoneA));

  sec_reg_gate #(.REG_BASE(BASE), .LAYOUT_B(1'b1)) i_sec_reg_gate_b (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(readyB),
    .reqFunc(reqFunc), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValidB), .rspErr(rspErrB), .rspRdata(rspRdataB),
    .busSel(busSelB), .busWrite(busWriteB), .busAddr(busAddrB),
    .busWdata(busWdataB), .busRdata(busRdataB), .busDone(busDoneB));

  // bus responders: done one cycle after select, data derived from address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busDoneA <= 1'b0;
      busDoneB <= 1'b0;
    end else begin
      busDoneA <= busSelA && !busDoneA;
      busDoneB <= busSelB && !busDoneB;
    end
  end
  assign busRdataA = busAddrA ^ 32'h5A5A_C3C3;
  assign busRdataB = busAddrB ^ 32'h5A5A_C3C3;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // allow list, written from the requirements
  function automatic bit refAllowed(logic [31:0] a, bit lb);
    logic [31:0] o;
    o = a - BASE;
    if (o == 32'h6F8008 || o == 32'h6F8240 || o == 32'h6F8244) return 1'b1;
    if (o >= 32'h6F8200 && o <= 32'h6F8204) return 1'b1;
    if (o >= 32'h6F8F00 && o <= 32'h6F8F1C) return 1'b1;
    if (o >= 32'h6F9000 && o <= 32'h6F93F8) return 1'b1;
    if (!lb)
      return o inside {32'h6F8278, 32'h6F828C, 32'h6F8280, 32'h6F8294,
                       32'h6F8284, 32'h6F8298, 32'h6F8C94, 32'h6F8CA8};
    return o inside {32'h6F8278, 32'h6F8280, 32'h6F827C, 32'h6F8284,
                     32'h6F8C98, 32'h6F8CA0};
  endfunction

  function automatic string reqTag(logic [7:0] f, logic [31:0] a, bit lb);
    logic [31:0] o;
    o = a - BASE;
    if (f != 8'd20 && f != 8'd21) return "R3";
    if ((o >= 32'h6F81FF && o <= 32'h6F8205) || (o >= 32'h6F8EFF && o <= 32'h6F8F1D) ||
        (o >= 32'h6F8FFF && o <= 32'h6F93F9)) return "R5";
    if (o inside {32'h6F8007, 32'h6F8008, 32'h6F8009, 32'h6F823F, 32'h6F8240,
                  32'h6F8244, 32'h6F8245}) return "R6";
    if (o >= 32'h6F8270 && o <= 32'h6F8CB0) return lb ? "R8" : "R7";
    if (!refAllowed(a, lb)) return "R4";
    return (f == 8'd20) ? "R1" : "R2";
  endfunction

  task automatic applyReq(input logic [7:0] f, input logic [31:0] a, input logic [31:0] wd);
    bit got[2];
    bit seenBus[2];
    bit seenWr[2];
    logic [31:0] bAddr[2];
    logic [31:0] bWd[2];
    bit err[2];
    logic [31:0] rd[2];
    int lat[2];
    got = '{0, 0}; seenBus = '{0, 0}; seenWr = '{0, 0};
    bAddr = '{0, 0}; bWd = '{0, 0}; err = '{0, 0}; rd = '{0, 0}; lat = '{0, 0};
    @(negedge clk);
    check(readyA && readyB, "R9", "ready when idle", {30'd0, readyB, readyA}, 32'd3);
    reqValid = 1'b1; reqFunc = f; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    reqFunc = 8'($urandom); reqAddr = $urandom; reqWdata = $urandom;
    for (int k = 1; k <= 8; k++) begin
      if (k == 1)
        check(!readyA && !readyB, "R9", "ready after accept", {30'd0, readyB, readyA}, 32'd0);
      if (busSelA && !seenBus[0]) begin
        seenBus[0] = 1; seenWr[0] = busWriteA; bAddr[0] = busAddrA; bWd[0] = busWdataA;
      end
      if (busSelB && !seenBus[1]) begin
        seenBus[1] = 1; seenWr[1] = busWriteB; bAddr[1] = busAddrB; bWd[1] = busWdataB;
      end
      if (rspValidA && !got[0]) begin got[0] = 1; err[0] = rspErrA; rd[0] = rspRdataA; lat[0] = k; end
      if (rspValidB && !got[1]) begin got[1] = 1; err[1] = rspErrB; rd[1] = rspRdataB; lat[1] = k; end
      @(negedge clk);
    end
    for (int d = 0; d < 2; d++) begin
      bit lb;
      bit expOk;
      string tag;
      lb = (d == 1);
      expOk = (f == 8'd20 || f == 8'd21) && refAllowed(a, lb);
      tag = reqTag(f, a, lb);
      check(got[d], tag, "response seen", {31'd0, got[d]}, 32'd1);
      check(err[d] == !expOk, tag, "error flag", {31'd0, err[d]}, {31'd0, !expOk});
      check(seenBus[d] == expOk, tag, "bus touched", {31'd0, seenBus[d]}, {31'd0, expOk});
      if (expOk) begin
        check(bAddr[d] == a, tag, "bus address", bAddr[d], a);
        check(seenWr[d] == (f == 8'd21), tag, "bus direction", {31'd0, seenWr[d]},
              {31'd0, f == 8'd21});
        if (f == 8'd21) begin
          check(bWd[d] == wd, "R2", "bus wdata", bWd[d], wd);
          check(rd[d] == 32'd0, "R2", "write rdata", rd[d], 32'd0);
        end else begin
          check(rd[d] == (a ^ 32'h5A5A_C3C3), "R1", "read data", rd[d], a ^ 32'h5A5A_C3C3);
        end
      end else begin
        check(rd[d] == 32'd0, tag, "error rdata", rd[d], 32'd0);
        check(lat[d] == 2, "R9", "error latency", lat[d], 32'd2);
      end
    end
  endtask

  function automatic logic [31:0] anchor(int idx);
    case (idx)
      0: return 32'h6F8008;  1: return 32'h6F8240;  2: return 32'h6F8244;
      3: return 32'h6F8200;  4: return 32'h6F8204;  5: return 32'h6F8F00;
      6: return 32'h6F8F1C;  7: return 32'h6F9000;  8: return 32'h6F93F8;
      9: return 32'h6F8278; 10: return 32'h6F8280; 11: return 32'h6F8284;
      12: return 32'h6F8C94; 13: return 32'h6F827C; 14: return 32'h6F8C98;
      15: return 32'h6F828C; 16: return 32'h6F8298; 17: return 32'h6F8CA8;
      default: return 32'h6F8CA0;
    endcase
  endfunction

  initial begin
    #4_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240421));
    repeat (3) @(negedge clk);
    // reset state
    check(!rspValidA && !busSelA && readyA, "R9", "reset A",
          {29'd0, rspValidA, busSelA, readyA}, 32'd1);
    check(!rspValidB && !busSelB && readyB, "R9", "reset B",
          {29'd0, rspValidB, busSelB, readyB}, 32'd1);
    rstN = 1'b1;
    // directed: every anchor with both operations and one byte either side
    for (int i = 0; i < 19; i++) begin
      applyReq(8'd20, BASE + anchor(i), 32'h0);
      applyReq(8'd21, BASE + anchor(i), 32'hC0DE_0000 + i);
      applyReq(8'd20, BASE + anchor(i) - 1, 32'h0);
      applyReq(8'd21, BASE + anchor(i) + 1, 32'h1111_2222);
    end
    // R3: neighbouring and zero codes at an allowed address
    applyReq(8'd19, BASE + 32'h6F8240, 32'h0);
    applyReq(8'd22, BASE + 32'h6F8240, 32'h0);
    applyReq(8'd0,  BASE + 32'h6F9000, 32'h0);
    // R4: far outside, below base, wrapped
    applyReq(8'd20, 32'h0000_0000, 32'h0);
    applyReq(8'd21, 32'hFFFF_FFFC, 32'h0);
    applyReq(8'd20, 32'h006F_8240, 32'h0);
    // random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] f;
      logic [31:0] a;
      int sel;
      sel = int'($urandom_range(0, 19));
      if (sel < 9) f = 8'd20;
      else if (sel < 18) f = 8'd21;
      else f = 8'($urandom);
      if ($urandom_range(0, 7) == 0) a = $urandom;
      else a = BASE + anchor(int'($urandom_range(0, 18))) + 32'($urandom_range(0, 6)) - 32'd3;
      applyReq(f, a, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule